// File: doc/BRIEF.md
# Cellular Bitmap Compaction Engine

This block holds a small two-dimensional grid of sites that together store the bitmap of a planar graph layout. Each site keeps a two-bit type code and one movable flag. All sites update together, each reading its four direct neighbours. The array pushes the drawing one grid point toward the east border per step and keeps the graph's connections intact. It repeats steps until nothing can move.

A host writes the bitmap one row at a time while the block is idle. It then pulses `start`, optionally with `jog_elim` set, and waits for `done`. It reads the compacted rows back through a combinational row port.

The controller is a four-state machine:
- `S_IDLE`: loading is allowed.
- `S_MARK`: every edge or node site is flagged movable.
- `S_SETTLE`: demotes movable sites to stationary, one pass per cycle, until a pass changes nothing.
- `S_SHIFT`: moves every movable site one column east.

The transitions are:
- start: `S_IDLE` to `S_MARK`.
- settle entry: `S_MARK` to `S_SETTLE`.
- demote again: `S_SETTLE` to `S_SETTLE`.
- commit: `S_SETTLE` to `S_SHIFT`.
- next step: `S_SHIFT` to `S_MARK`.
- finish: `S_SETTLE` to `S_IDLE`, taken when no site is left movable. This transition raises `done`.

Top module: `cca_compactor`

## Requirements
- R1: Type codes are EMPTY=00, EDGE=01, NODE=10, OBSTACLE=11. A cycle with `load_en` high in idle writes row `load_row`, with column c taken from bits [2c+1:2c] of `load_data`. `rd_data` returns row `rd_row` in the same layout, combinationally.
- R2: After reset every site is EMPTY and both `busy` and `done` are low.
- R3: While `busy` is high, `load_en`, `start` and `jog_elim` have no effect on the grid or on the run. The mode is captured in the cycle `start` is accepted.
- R4: At the start of each step, every EDGE and NODE site becomes movable. EMPTY and OBSTACLE sites stay stationary.
- R5: A movable site is demoted when its east neighbour is non-empty and stationary. The area beyond the east border counts as a stationary obstacle.
- R6: A movable NODE is demoted when any of its north, east, south or west neighbours is a stationary NODE, so a module never splits.
- R7: With the jog-elimination mode captured, a movable EDGE is demoted when its north or south neighbour is a stationary EDGE. With the mode off, this rule does not apply.
- R8: Demotion runs one pass per cycle and stops after the first pass that changes no site.
- R9: In a shift, a site whose west neighbour is movable takes that neighbour's type. Stationary non-empty sites keep their type.
- R10: In a shift, a movable site whose west neighbour is not movable becomes one of the following. It becomes EDGE when the west neighbour is a stationary EDGE or NODE. Otherwise it becomes EDGE when its north or south neighbour is a stationary EDGE or NODE. Otherwise it becomes EMPTY.
- R11: `done` rises, and `busy` falls, after the settle pass of a step that leaves no site movable. Counting clock edges after the one that accepts `start`, one step with k demoting passes takes k+3 edges, and the final step takes k+2. `done` stays high until the next accepted start.
- R12: Every shift leaves the number of NODE sites unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Write one row (idle only) |
| load_row | input | $clog2(ROWS) | Row written |
| load_data | input | 2*COLS | Row types, column c at [2c+1:2c] |
| jog_elim | input | 1 | Jog-elimination mode, captured at start |
| start | input | 1 | Begin compaction (idle only) |
| rd_row | input | $clog2(ROWS) | Row read |
| rd_data | output | 2*COLS | Types of row `rd_row` |
| busy | output | 1 | Compaction in progress |
| done | output | 1 | Last run finished |

## Verification
The assertions take for granted that `rst_n` is asserted before the first run. They also assume the loaded bitmap uses only the four type codes. Any two-bit value is legal, so the random layouts stay within that assumption by construction. The stimulus holds `start` and `load_en` to single idle cycles, except for a deliberate burst while busy that checks they are ignored. Timing is judged against a behavioural model that counts demotion passes to predict the exact edge on which `done` rises.

// File: rtl/cca_pkg.sv
package cca_pkg;

    typedef enum logic [1:0] {
        CT_EMPTY = 2'b00,
        CT_EDGE  = 2'b01,
        CT_NODE  = 2'b10,
        CT_OBST  = 2'b11
    } cell_t;

    typedef enum logic [1:0] {
        PH_HOLD,
        PH_MARK,
        PH_SETTLE,
        PH_SHIFT
    } phase_t;

    typedef struct packed {
        cell_t kind;
        logic  mov;
    } site_t;

    localparam site_t SITE_VOID = '{kind: CT_EMPTY, mov: 1'b0};
    localparam site_t SITE_WALL = '{kind: CT_OBST,  mov: 1'b0};

endpackage

// File: rtl/cca_site.sv
module cca_site
    import cca_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_t phase,
    input  logic   jog_en,
    input  logic   wr_en,
    input  cell_t  wr_kind,
    input  site_t  nb_n,
    input  site_t  nb_s,
    input  site_t  nb_e,
    input  site_t  nb_w,
    output site_t  cur,
    output logic   demote
);

    site_t nxt;

    function automatic logic wired(site_t s);
        return (s.kind == CT_EDGE) || (s.kind == CT_NODE);
    endfunction

    function automatic logic fixed_wired(site_t s);
        return wired(s) && !s.mov;
    endfunction

    function automatic logic fixed_node(site_t s);
        return (s.kind == CT_NODE) && !s.mov;
    endfunction

    function automatic logic fixed_edge(site_t s);
        return (s.kind == CT_EDGE) && !s.mov;
    endfunction

    logic blocked_east;
    logic module_tied;
    logic run_tied;
    logic anchored;

    always_comb begin
        blocked_east = (nb_e.kind != CT_EMPTY) && !nb_e.mov;
        module_tied  = (cur.kind == CT_NODE) &&
                       (fixed_node(nb_n) || fixed_node(nb_s) ||
                        fixed_node(nb_e) || fixed_node(nb_w));
        run_tied     = jog_en && (cur.kind == CT_EDGE) &&
                       (fixed_edge(nb_n) || fixed_edge(nb_s));
        anchored     = fixed_wired(nb_n) || fixed_wired(nb_s);
        demote       = cur.mov && (blocked_east || module_tied || run_tied);
    end

    always_comb begin
        nxt = cur;
        unique case (phase)
            PH_HOLD: begin
                if (wr_en) begin
                    nxt.kind = wr_kind;
                    nxt.mov  = 1'b0;
                end
            end
            PH_MARK: begin
                nxt.mov = wired(cur);
            end
            PH_SETTLE: begin
                if (demote) nxt.mov = 1'b0;
            end
            PH_SHIFT: begin
                nxt.mov = 1'b0;
                if ((cur.kind != CT_EMPTY) && !cur.mov) begin
                    nxt.kind = cur.kind;
                end else if (nb_w.mov) begin
                    nxt.kind = nb_w.kind;
                end else if (cur.mov) begin
                    if (fixed_wired(nb_w))  nxt.kind = CT_EDGE;
                    else if (anchored)      nxt.kind = CT_EDGE;
                    else                    nxt.kind = CT_EMPTY;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= SITE_VOID;
        else        cur <= nxt;
    end

endmodule

// File: rtl/cca_ctrl.sv
module cca_ctrl
    import cca_pkg::*;
#(
    parameter int CAP = 64
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   jog_req,
    input  logic   any_mov,
    input  logic   any_dem,
    output phase_t phase,
    output logic   busy,
    output logic   done,
    output logic   jog_en
);

    localparam int IW = $clog2(CAP + 1);

    typedef enum logic [1:0] {
        S_IDLE,
        S_MARK,
        S_SETTLE,
        S_SHIFT
    } state_t;

    state_t         st, st_nx;
    logic [IW-1:0]  iter;
    logic           again;

    always_comb begin
        again = any_dem && (iter != IW'(CAP - 1));
        st_nx = st;
        unique case (st)
            S_IDLE:   if (start) st_nx = S_MARK;
            S_MARK:   st_nx = S_SETTLE;
            S_SETTLE: begin
                if (again)        st_nx = S_SETTLE;
                else if (any_mov) st_nx = S_SHIFT;
                else              st_nx = S_IDLE;
            end
            S_SHIFT:  st_nx = S_MARK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            iter   <= '0;
            done   <= 1'b0;
            jog_en <= 1'b0;
        end else begin
            st <= st_nx;
            if (st == S_IDLE && start) begin
                done   <= 1'b0;
                jog_en <= jog_req;
            end
            if (st == S_SETTLE && st_nx == S_IDLE) done <= 1'b1;
            if (st == S_MARK)
                iter <= '0;
            else if (st == S_SETTLE && st_nx == S_SETTLE)
                iter <= iter + 1'b1;
        end
    end

    always_comb begin
        phase = PH_HOLD;
        busy  = 1'b1;
        unique case (st)
            S_IDLE:   begin phase = PH_HOLD;   busy = 1'b0; end
            S_MARK:   phase = PH_MARK;
            S_SETTLE: phase = PH_SETTLE;
            S_SHIFT:  phase = PH_SHIFT;
        endcase
    end

endmodule

// File: rtl/cca_compactor.sv
module cca_compactor
    import cca_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_en,
    input  logic [$clog2(ROWS)-1:0]  load_row,
    input  logic [2*COLS-1:0]        load_data,
    input  logic                     jog_elim,
    input  logic                     start,
    input  logic [$clog2(ROWS)-1:0]  rd_row,
    output logic [2*COLS-1:0]        rd_data,
    output logic                     busy,
    output logic                     done
);

    localparam int NSITE = ROWS * COLS;
    localparam int RW    = $clog2(ROWS);

    site_t              grid [ROWS][COLS];
    logic [NSITE-1:0]   dem_v;
    logic [NSITE-1:0]   mov_v;
    logic [NSITE-1:0]   node_v;
    phase_t             phase;
    logic               jog_en;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            site_t n_i, s_i, e_i, w_i;
            logic  we_i;

            if (r == 0)        begin : g_n0 assign n_i = SITE_VOID;        end
            else               begin : g_n1 assign n_i = grid[r-1][c];     end
            if (r == ROWS - 1) begin : g_s0 assign s_i = SITE_VOID;        end
            else               begin : g_s1 assign s_i = grid[r+1][c];     end
            if (c == COLS - 1) begin : g_e0 assign e_i = SITE_WALL;        end
            else               begin : g_e1 assign e_i = grid[r][c+1];     end
            if (c == 0)        begin : g_w0 assign w_i = SITE_VOID;        end
            else               begin : g_w1 assign w_i = grid[r][c-1];     end

            assign we_i = load_en && (load_row == RW'(r));

            cca_site u_site (
                .clk     (clk),
                .rst_n   (rst_n),
                .phase   (phase),
                .jog_en  (jog_en),
                .wr_en   (we_i),
                .wr_kind (cell_t'(load_data[2*c +: 2])),
                .nb_n    (n_i),
                .nb_s    (s_i),
                .nb_e    (e_i),
                .nb_w    (w_i),
                .cur     (grid[r][c]),
                .demote  (dem_v[r*COLS + c])
            );

            assign mov_v[r*COLS + c]  = grid[r][c].mov;
            assign node_v[r*COLS + c] = (grid[r][c].kind == CT_NODE);
        end
    end

    cca_ctrl #(.CAP(NSITE)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .jog_req (jog_elim),
        .any_mov (|mov_v),
        .any_dem (|dem_v),
        .phase   (phase),
        .busy    (busy),
        .done    (done),
        .jog_en  (jog_en)
    );

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < COLS; c++) begin
            if (int'(rd_row) < ROWS) rd_data[2*c +: 2] = grid[rd_row][c].kind;
        end
    end

endmodule

// File: rtl/cca_compactor_chk.sv
module cca_compactor_chk
    import cca_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 done,
    input phase_t               phase,
    input logic [ROWS*COLS-1:0] mov_v,
    input logic [ROWS*COLS-1:0] node_v
);

    logic [ROWS-1:0] east_mov;

    always_comb begin
        for (int r = 0; r < ROWS; r++) east_mov[r] = mov_v[r*COLS + COLS - 1];
    end

    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_shift_has_work_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SHIFT) |-> (|mov_v));

    p_wall_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SHIFT) |-> (east_mov == '0));

    p_settle_shrinks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SETTLE) |=> ($countones(mov_v) <= $past($countones(mov_v))));

    p_nodes_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SHIFT) |=> ($countones(node_v) == $past($countones(node_v))));

    p_load_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (phase != PH_HOLD));

endmodule

bind cca_compactor cca_compactor_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .phase  (phase),
    .mov_v  (mov_v),
    .node_v (node_v)
);

// File: tb/cca_compactor_bench.sv
`timescale 1ns/1ps
module cca_compactor_bench;

    localparam int ROWS = 8;
    localparam int COLS = 8;
    localparam int RW   = $clog2(ROWS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_en = 1'b0;
    logic [RW-1:0]     load_row = '0;
    logic [2*COLS-1:0] load_data = '0;
    logic              jog_elim = 1'b0;
    logic              start = 1'b0;
    logic [RW-1:0]     rd_row = '0;
    logic [2*COLS-1:0] rd_data;
    logic              busy, done;

    always #2 clk = ~clk;

    cca_compactor #(.ROWS(ROWS), .COLS(COLS)) u_cca_compactor (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_row(load_row),
        .load_data(load_data), .jog_elim(jog_elim), .start(start),
        .rd_row(rd_row), .rd_data(rd_data), .busy(busy), .done(done)
    );

    int checks = 0;
    int errors = 0;
    int pat [ROWS][COLS];
    int mt  [ROWS][COLS];
    int mm  [ROWS][COLS];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int kt(int r, int c);
        if (c >= COLS) return 3;
        if (r < 0 || r >= ROWS || c < 0) return 0;
        return mt[r][c];
    endfunction

    function automatic int km(int r, int c);
        if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return 0;
        return mm[r][c];
    endfunction

    function automatic bit wired_st(int r, int c);
        return (kt(r, c) == 1 || kt(r, c) == 2) && km(r, c) == 0;
    endfunction

    function automatic bit node_st(int r, int c);
        return kt(r, c) == 2 && km(r, c) == 0;
    endfunction

    function automatic bit edge_st(int r, int c);
        return kt(r, c) == 1 && km(r, c) == 0;
    endfunction

    // Behavioural model of the whole run; returns the clock-edge count to done.
    task automatic model_run(input bit jog, output int edges);
        int nd [ROWS][COLS];
        int nt [ROWS][COLS];
        bit changed, any;
        edges = 0;
        for (int step = 0; step < 200; step++) begin
            foreach (mt[r, c]) mm[r][c] = (mt[r][c] == 1 || mt[r][c] == 2);
            edges++;
            do begin
                changed = 0;
                foreach (mt[r, c]) begin
                    nd[r][c] = mm[r][c];
                    if (mm[r][c] != 0) begin
                        if ((kt(r, c+1) != 0 && km(r, c+1) == 0) ||
                            (mt[r][c] == 2 && (node_st(r-1, c) || node_st(r+1, c) ||
                                               node_st(r, c+1) || node_st(r, c-1))) ||
                            (jog && mt[r][c] == 1 && (edge_st(r-1, c) || edge_st(r+1, c)))) begin
                            nd[r][c] = 0;
                            changed = 1;
                        end
                    end
                end
                if (changed) begin
                    edges++;
                    foreach (mm[r, c]) mm[r][c] = nd[r][c];
                end
            end while (changed);
            edges++;
            any = 0;
            foreach (mm[r, c]) if (mm[r][c] != 0) any = 1;
            if (!any) break;
            foreach (mt[r, c]) begin
                nt[r][c] = mt[r][c];
                if (mt[r][c] != 0 && mm[r][c] == 0) nt[r][c] = mt[r][c];
                else if (km(r, c-1) != 0) nt[r][c] = kt(r, c-1);
                else if (mm[r][c] != 0) begin
                    if (wired_st(r, c-1)) nt[r][c] = 1;
                    else if (wired_st(r-1, c) || wired_st(r+1, c)) nt[r][c] = 1;
                    else nt[r][c] = 0;
                end
            end
            edges++;
            foreach (mt[r, c]) begin
                mt[r][c] = nt[r][c];
                mm[r][c] = 0;
            end
        end
    endtask

    task automatic clear_pat();
        foreach (pat[r, c]) pat[r][c] = 0;
    endtask

    task automatic load_pat();
        for (int r = 0; r < ROWS; r++) begin
            @(negedge clk);
            load_en  = 1'b1;
            load_row = RW'(r);
            for (int c = 0; c < COLS; c++) load_data[2*c +: 2] = 2'(pat[r][c]);
        end
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic read_cell(input int r, input int c, output int v);
        rd_row = RW'(r);
        #0.5;
        v = int'(rd_data[2*c +: 2]);
    endtask

    task automatic run_case(input string name, input bit jog, input bit poke);
        int e, n0, n1, v, bad, rowbad;
        load_pat();
        n0 = 0;
        foreach (pat[r, c]) begin
            mt[r][c] = pat[r][c];
            if (pat[r][c] == 2) n0++;
        end
        model_run(jog, e);
        @(negedge clk);
        start = 1'b1;
        jog_elim = jog;
        @(negedge clk);
        start = 1'b0;
        bad = 0;
        for (int k = 1; k <= e; k++) begin
            if (poke && k == 1) begin
                load_en = 1'b1; load_row = '0; load_data = '1;
                start = 1'b1; jog_elim = !jog;
            end
            @(negedge clk);
            load_en = 1'b0;
            start = 1'b0;
            if (k < e && (!busy || done)) bad++;
        end
        // R8 R11: done rises on exactly the predicted edge
        chk(bad == 0 && done && !busy, "R11", {name, " done timing"}, int'(done), 1);
        n1 = 0;
        for (int r = 0; r < ROWS; r++) begin
            rowbad = 0;
            for (int c = 0; c < COLS; c++) begin
                read_cell(r, c, v);
                if (v != mt[r][c]) rowbad++;
                if (v == 2) n1++;
            end
            // R9 R10: compacted row matches the model
            chk(rowbad == 0, "R9 R10", {name, " row mismatches"}, rowbad, 0);
        end
        chk(n1 == n0, "R12", {name, " node count"}, n1, n0);
        repeat (3) @(negedge clk);
        chk(done == 1'b1, "R11", {name, " done held"}, int'(done), 1);
    endtask

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL R11 watchdog: got 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v, bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk(busy == 1'b0, "R2", "busy after reset", int'(busy), 0);
        chk(done == 1'b0, "R2", "done after reset", int'(done), 0);
        bad = 0;
        for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) begin
            read_cell(r, c, v); if (v != 0) bad++;
        end
        chk(bad == 0, "R2", "non-empty sites after reset", bad, 0);

        // R1 load and read back
        clear_pat();
        pat[3][1] = 2; pat[3][2] = 1; pat[3][3] = 1; pat[3][4] = 2; pat[0][0] = 3;
        load_pat();
        bad = 0;
        for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) begin
            read_cell(r, c, v); if (v != pat[r][c]) bad++;
        end
        chk(bad == 0, "R1", "readback mismatches", bad, 0);

        // R4 R5 R3: horizontal chain slides to the wall, poked while busy
        run_case("chain", 1'b0, 1'b1);
        read_cell(3, 7, v);
        chk(v == 2, "R5", "chain end at wall", v, 2);

        // R11: empty grid finishes after mark and one pass
        clear_pat();
        run_case("empty", 1'b0, 1'b0);

        // R4 R5: column of nodes already at the wall
        clear_pat();
        for (int r = 0; r < ROWS; r++) pat[r][7] = 2;
        run_case("wallcol", 1'b0, 1'b0);

        // R6: two-by-two module with its top row blocked
        clear_pat();
        pat[1][5] = 2; pat[1][6] = 2; pat[2][5] = 2; pat[2][6] = 2; pat[1][7] = 3;
        run_case("module", 1'b0, 1'b0);
        read_cell(2, 6, v);
        chk(v == 2, "R6", "module lower corner kept", v, 2);
        read_cell(2, 7, v);
        chk(v == 0, "R6", "module did not split east", v, 0);

        // R7: vertical edge run with a blocked middle, both modes
        clear_pat();
        for (int r = 1; r <= 5; r++) pat[r][2] = 1;
        pat[3][3] = 3;
        run_case("run_jog", 1'b1, 1'b0);
        read_cell(1, 2, v);
        chk(v == 1, "R7", "run top held in jog mode", v, 1);
        run_case("run_plain", 1'b0, 1'b0);

        // R10 R12: node with vertical tethers to a stationary anchor
        clear_pat();
        pat[2][1] = 2; pat[3][1] = 1; pat[4][1] = 1; pat[5][1] = 2; pat[5][2] = 3;
        pat[1][4] = 2; pat[1][5] = 1; pat[1][6] = 3;
        run_case("tether", 1'b0, 1'b0);
        run_case("tether_jog", 1'b1, 1'b0);

        // R12: pseudo-random layouts
        for (int t = 0; t < 4; t++) begin
            clear_pat();
            foreach (pat[r, c]) begin
                int d = int'($urandom_range(0, 9));
                pat[r][c] = (d < 6) ? 0 : (d < 8) ? 1 : (d < 9) ? 2 : 3;
            end
            run_case("random", t[0], 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule